// File: doc/BRIEF.md
# Processor Register Bank with Role-Bound Entries

This block is the architectural register storage of a small 16-bit processor. It keeps sixteen 16-bit entries. The four lowest indices have fixed jobs: index 0 is the program counter, index 1 the stack pointer, index 2 the status word and index 3 a constant source. Indices 4 to 15 are plain working registers. Two read ports are combinational. A single write port commits on the clock edge and can write a whole word or a single byte.

Three side paths share the same clock edge. The first steps a pointer register for post-increment addressing. The second loads a new program counter. The third drops fresh arithmetic flags into the status word. When a source-mode code is given, read port A returns generated constants: index 3 always supplies them, and index 2 supplies them in the two indirect modes. Instruction decode, arithmetic and memory access sit outside this block.

The reset is asynchronous and active low. It is expected to be released synchronously by a reset synchronizer upstream.

Top module: `cpu_regbank`

## Requirements
- R1: While `rst_n` is low, every entry is zero except the program counter, which holds `rst_vec` with bit 0 cleared.
- R2: A word write (`wr_en`=1, `wr_byte`=0) to indices 2 and 4–15 stores `wr_data` unchanged at the clock edge. Both read ports show stored values combinationally, so the new value appears in the cycle after the write.
- R3: A byte write (`wr_byte`=1) stores `wr_data[7:0]` in the low byte and zero in the high byte.
- R4: Every update of index 0 or index 1 (write, step or program counter load) stores bit 0 as zero.
- R5: Index 3 ignores all writes and steps. Port A returns 0x0000, 0x0001, 0x0002 or 0xFFFF for `rd_a_mode` 0, 1, 2 or 3. Port B returns 0x0000 for index 3.
- R6: For index 2, port A returns the stored word when `rd_a_mode` is 0 or 1, 0x0004 when it is 2, and 0x0008 when it is 3. Port B always returns the stored word.
- R7: The step path (`inc_en`) adds 2 to the entry at `inc_idx` when `inc_byte`=0 and adds 1 when `inc_byte`=1. Indices 0 and 1 always step by 2. The sum wraps modulo 2^16.
- R8: When the write port and the step path target the same entry in the same cycle, the written value is stored.
- R9: `pc_en`=1 loads `pc_data` (bit 0 cleared) into index 0. This load has priority over the write port and the step path.
- R10: `flg_en`=1 copies `flg_val[0]`, `[1]`, `[2]` and `[3]` (carry, zero, negative, overflow) into status bits 0, 1, 2 and 8. These bits win over a same-cycle write to index 2. The other status bits take that write if there is one, and otherwise keep their value.
- R11: `pc_out`, `sp_out` and `sr_out` always show the stored contents of indices 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_vec | input | 16 | Program counter value applied during reset |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_mode | input | 2 | Source mode for port A constant generation |
| rd_a_data | output | 16 | Read port A data |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 16 | Read port B data (direct mode) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write index |
| wr_byte | input | 1 | Byte-sized write |
| wr_data | input | 16 | Write data |
| inc_en | input | 1 | Pointer step enable |
| inc_idx | input | 4 | Pointer step index |
| inc_byte | input | 1 | Byte-sized step |
| pc_en | input | 1 | Program counter load enable |
| pc_data | input | 16 | Program counter load value |
| flg_en | input | 1 | Flag update enable |
| flg_val | input | 4 | Flags {overflow, negative, zero, carry} |
| pc_out | output | 16 | Stored program counter |
| sp_out | output | 16 | Stored stack pointer |
| sr_out | output | 16 | Stored status word |

## Verification
The bound checker watches these rules on every cycle:
- the alignment of the program counter and stack pointer;
- the constant values on port A;
- the program counter load priority;
- the flag bit placement, and the hold of the other status bits when nothing else writes them;
- the cleared high byte after a byte write to the stack pointer.

Some rules can only be shown by the bench's scenarios, because they need a read-back of general entries through the ports. These are the byte write and word write results, the step sizes and their wrap, and the rule that the write port wins over the step path. The bench covers them with a reference model over random traffic and with directed corner cases.

// File: rtl/cpu_regbank_pkg.sv
package cpu_regbank_pkg;

  localparam int unsigned IDX_PC = 0;
  localparam int unsigned IDX_SP = 1;
  localparam int unsigned IDX_SR = 2;
  localparam int unsigned IDX_CG = 3;

  localparam int unsigned FLAG_C = 0;
  localparam int unsigned FLAG_Z = 1;
  localparam int unsigned FLAG_N = 2;
  localparam int unsigned FLAG_V = 8;

  typedef enum logic [1:0] {
    SRC_DIRECT   = 2'd0,
    SRC_INDEXED  = 2'd1,
    SRC_INDIRECT = 2'd2,
    SRC_POSTINC  = 2'd3
  } src_mode_e;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;

endpackage

// File: rtl/rb_const_gen.sv
module rb_const_gen
  import cpu_regbank_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 4
) (
  input  logic [AW-1:0] idx,
  input  logic [1:0]    mode,
  input  logic [DW-1:0] stored,
  output logic [DW-1:0] value
);

  src_mode_e mode_e;
  assign mode_e = src_mode_e'(mode);

  always_comb begin
    value = stored;
    if (idx == AW'(IDX_CG)) begin
      unique case (mode_e)
        SRC_DIRECT:   value = '0;
        SRC_INDEXED:  value = DW'(1);
        SRC_INDIRECT: value = DW'(2);
        default:      value = '1;
      endcase
    end else if (idx == AW'(IDX_SR)) begin
      if (mode_e == SRC_INDIRECT) value = DW'(4);
      else if (mode_e == SRC_POSTINC) value = DW'(8);
    end
  end

endmodule

// File: rtl/rb_write_prep.sv
module rb_write_prep #(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] wr_data,
  input  logic          wr_byte,
  output logic [DW-1:0] wdata
);

  localparam int unsigned HALF = DW / 2;

  always_comb begin
    if (wr_byte) wdata = {{(DW-HALF){1'b0}}, wr_data[HALF-1:0]};
    else         wdata = wr_data;
  end

endmodule

// File: rtl/rb_incr_unit.sv
module rb_incr_unit
  import cpu_regbank_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 4
) (
  input  logic [AW-1:0] idx,
  input  logic          byte_step,
  input  logic [DW-1:0] cur,
  output logic [DW-1:0] nxt
);

  logic [DW-1:0] step;

  always_comb begin
    if (byte_step && (idx > AW'(IDX_SP))) step = DW'(1);
    else                                  step = DW'(2);
    nxt = cur + step;
  end

endmodule

// File: rtl/cpu_regbank.sv
module cpu_regbank
  import cpu_regbank_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DW-1:0]           rst_vec,
  input  logic [$clog2(NREG)-1:0] rd_a_idx,
  input  logic [1:0]              rd_a_mode,
  output logic [DW-1:0]           rd_a_data,
  input  logic [$clog2(NREG)-1:0] rd_b_idx,
  output logic [DW-1:0]           rd_b_data,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic                    wr_byte,
  input  logic [DW-1:0]           wr_data,
  input  logic                    inc_en,
  input  logic [$clog2(NREG)-1:0] inc_idx,
  input  logic                    inc_byte,
  input  logic                    pc_en,
  input  logic [DW-1:0]           pc_data,
  input  logic                    flg_en,
  input  logic [3:0]              flg_val,
  output logic [DW-1:0]           pc_out,
  output logic [DW-1:0]           sp_out,
  output logic [DW-1:0]           sr_out
);

  localparam int unsigned AW = $clog2(NREG);

  logic [DW-1:0] regs_q [NREG];
  logic [DW-1:0] nxt_d  [NREG];
  logic [NREG-1:0] ce_d;

  logic [DW-1:0] wdata;
  logic [DW-1:0] inc_val;
  flags_t        flg;

  assign flg = flags_t'(flg_val);

  rb_write_prep #(.DW(DW)) u_wprep (
    .wr_data (wr_data),
    .wr_byte (wr_byte),
    .wdata   (wdata)
  );

  rb_incr_unit #(.DW(DW), .AW(AW)) u_incr (
    .idx       (inc_idx),
    .byte_step (inc_byte),
    .cur       (regs_q[inc_idx]),
    .nxt       (inc_val)
  );

  // Per-entry next-state selection; the variant depends on the entry's role.
  for (genvar g = 0; g < NREG; g++) begin : g_ent
    if (g == IDX_CG) begin : g_const
      assign nxt_d[g] = '0;
      assign ce_d[g]  = 1'b0;
    end else begin : g_store
      logic          hit_w, hit_i, sel_en, fin_en;
      logic [DW-1:0] sel, fin;

      always_comb begin
        hit_w  = wr_en  && (wr_idx  == AW'(g));
        hit_i  = inc_en && (inc_idx == AW'(g));
        sel    = hit_w ? wdata : inc_val;
        sel_en = hit_w || hit_i;
      end

      if (g == IDX_PC) begin : g_pc
        always_comb begin
          fin    = sel;
          fin_en = sel_en;
          if (pc_en) begin
            fin    = pc_data;
            fin_en = 1'b1;
          end
          fin[0] = 1'b0;
        end
      end else if (g == IDX_SP) begin : g_sp
        always_comb begin
          fin    = sel;
          fin[0] = 1'b0;
          fin_en = sel_en;
        end
      end else if (g == IDX_SR) begin : g_sr
        always_comb begin
          fin    = sel_en ? sel : regs_q[g];
          fin_en = sel_en || flg_en;
          if (flg_en) begin
            fin[FLAG_C] = flg.c;
            fin[FLAG_Z] = flg.z;
            fin[FLAG_N] = flg.n;
            fin[FLAG_V] = flg.v;
          end
        end
      end else begin : g_gp
        always_comb begin
          fin    = sel;
          fin_en = sel_en;
        end
      end

      assign nxt_d[g] = fin;
      assign ce_d[g]  = fin_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        if (i == IDX_PC) regs_q[i] <= {rst_vec[DW-1:1], 1'b0};
        else             regs_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (ce_d[i]) regs_q[i] <= nxt_d[i];
      end
    end
  end

  rb_const_gen #(.DW(DW), .AW(AW)) u_cg_a (
    .idx    (rd_a_idx),
    .mode   (rd_a_mode),
    .stored (regs_q[rd_a_idx]),
    .value  (rd_a_data)
  );

  rb_const_gen #(.DW(DW), .AW(AW)) u_cg_b (
    .idx    (rd_b_idx),
    .mode   (2'd0),
    .stored (regs_q[rd_b_idx]),
    .value  (rd_b_data)
  );

  assign pc_out = regs_q[IDX_PC];
  assign sp_out = regs_q[IDX_SP];
  assign sr_out = regs_q[IDX_SR];

endmodule

// File: rtl/cpu_regbank_chk.sv
module cpu_regbank_chk #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [$clog2(NREG)-1:0] rd_a_idx,
  input logic [1:0]              rd_a_mode,
  input logic [DW-1:0]           rd_a_data,
  input logic                    wr_en,
  input logic [$clog2(NREG)-1:0] wr_idx,
  input logic                    wr_byte,
  input logic                    inc_en,
  input logic [$clog2(NREG)-1:0] inc_idx,
  input logic                    pc_en,
  input logic [DW-1:0]           pc_data,
  input logic                    flg_en,
  input logic [3:0]              flg_val,
  input logic [DW-1:0]           pc_out,
  input logic [DW-1:0]           sp_out,
  input logic [DW-1:0]           sr_out
);

  localparam int unsigned AW = $clog2(NREG);

  a_r4_pc_even: assert property (@(posedge clk) disable iff (!rst_n)
    pc_out[0] == 1'b0);

  a_r4_sp_even: assert property (@(posedge clk) disable iff (!rst_n)
    sp_out[0] == 1'b0);

  a_r5_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == AW'(3) && rd_a_mode == 2'd3) |-> rd_a_data == '1);

  a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == AW'(3) && rd_a_mode == 2'd0) |-> rd_a_data == '0);

  a_r6_four: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == AW'(2) && rd_a_mode == 2'd2) |-> rd_a_data == DW'(4));

  a_r6_eight: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == AW'(2) && rd_a_mode == 2'd3) |-> rd_a_data == DW'(8));

  a_r9_pc_load: assert property (@(posedge clk) disable iff (!rst_n)
    pc_en |=> pc_out == {$past(pc_data[DW-1:1]), 1'b0});

  a_r10_flag_place: assert property (@(posedge clk) disable iff (!rst_n)
    flg_en |=> {sr_out[8], sr_out[2], sr_out[1], sr_out[0]} == $past(flg_val));

  a_r10_other_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_en && !(wr_en && wr_idx == AW'(2)) && !(inc_en && inc_idx == AW'(2)))
      |=> ({sr_out[DW-1:9], sr_out[7:3]} == $past({sr_out[DW-1:9], sr_out[7:3]})));

  a_r3_sp_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_byte && wr_idx == AW'(1)) |=> sp_out[DW-1:DW/2] == '0);

endmodule

bind cpu_regbank cpu_regbank_chk #(.DW(DW), .NREG(NREG)) chk_i (.*);

// File: tb/cpu_regbank_tb_top.sv
`timescale 1ns/1ps
module cpu_regbank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] rst_vec;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx, inc_idx;
  logic [1:0]  rd_a_mode;
  logic [15:0] rd_a_data, rd_b_data, wr_data, pc_data, pc_out, sp_out, sr_out;
  logic        wr_en, wr_byte, inc_en, inc_byte, pc_en, flg_en;
  logic [3:0]  flg_val;

  int total = 0;
  int bad   = 0;
  logic [15:0] m [16];

  always #4 clk = ~clk;

  cpu_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .rst_vec(rst_vec),
    .rd_a_idx(rd_a_idx), .rd_a_mode(rd_a_mode), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte), .wr_data(wr_data),
    .inc_en(inc_en), .inc_idx(inc_idx), .inc_byte(inc_byte),
    .pc_en(pc_en), .pc_data(pc_data), .flg_en(flg_en), .flg_val(flg_val),
    .pc_out(pc_out), .sp_out(sp_out), .sr_out(sr_out)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mread(logic [3:0] idx, logic [1:0] mode);
    if (idx == 4'd3) begin
      case (mode)
        2'd0: return 16'h0000;
        2'd1: return 16'h0001;
        2'd2: return 16'h0002;
        default: return 16'hFFFF;
      endcase
    end
    if (idx == 4'd2 && mode == 2'd2) return 16'h0004;
    if (idx == 4'd2 && mode == 2'd3) return 16'h0008;
    return m[idx];
  endfunction

  function automatic string rtag(logic [3:0] idx);
    if (idx == 4'd3) return "R5";
    if (idx == 4'd2) return "R6";
    return "R2";
  endfunction

  task automatic clr();
    wr_en = 0; wr_idx = 0; wr_byte = 0; wr_data = 0;
    inc_en = 0; inc_idx = 0; inc_byte = 0;
    pc_en = 0; pc_data = 0; flg_en = 0; flg_val = 0;
    rd_a_idx = 0; rd_a_mode = 0; rd_b_idx = 0;
  endtask

  // Check ports against the model, compute the expected next state, clock once.
  task automatic tick();
    logic [15:0] n [16];
    #1;
    chk(rtag(rd_a_idx), rd_a_data, mread(rd_a_idx, rd_a_mode));
    chk(rtag(rd_b_idx), rd_b_data, mread(rd_b_idx, 2'd0));
    chk("R11", pc_out, m[0]);
    chk("R11", sp_out, m[1]);
    chk("R11", sr_out, m[2]);
    n = m;
    if (inc_en && inc_idx != 4'd3)
      n[inc_idx] = m[inc_idx] + ((inc_byte && inc_idx > 4'd1) ? 16'd1 : 16'd2);
    if (wr_en && wr_idx != 4'd3)
      n[wr_idx] = wr_byte ? {8'h00, wr_data[7:0]} : wr_data;
    if (pc_en) n[0] = pc_data;
    n[0][0] = 1'b0;
    n[1][0] = 1'b0;
    if (flg_en) begin
      n[2][0] = flg_val[0];
      n[2][1] = flg_val[1];
      n[2][2] = flg_val[2];
      n[2][8] = flg_val[3];
    end
    @(posedge clk);
    m = n;
    @(negedge clk);
    clr();
  endtask

  task automatic peek(string req, logic [3:0] idx, logic [15:0] exp);
    rd_b_idx = idx;
    #1;
    chk(req, rd_b_data, exp);
  endtask

  task automatic wr(logic [3:0] idx, logic [15:0] d, logic b);
    wr_en = 1; wr_idx = idx; wr_data = d; wr_byte = b;
    tick();
  endtask

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clr();
    rst_n   = 1'b0;
    rst_vec = 16'hC0DF;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", pc_out, 16'hC0DE);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) m[i] = 16'h0000;
    m[0] = 16'hC0DE;
    #1;
    chk("R1", sp_out, 16'h0000);
    chk("R1", sr_out, 16'h0000);
    for (int i = 4; i < 16; i++) peek("R1", 4'(i), 16'h0000);

    // R2: word write visible next cycle
    wr(4'd9, 16'hBEEF, 1'b0);
    peek("R2", 4'd9, 16'hBEEF);

    // R3: byte write clears high byte
    wr(4'd5, 16'hABCD, 1'b1);
    peek("R3", 4'd5, 16'h00CD);

    // R4: stack pointer alignment
    wr(4'd1, 16'h1235, 1'b0);
    chk("R4", sp_out, 16'h1234);

    // R9: program counter load beats write and step on index 0
    pc_en = 1; pc_data = 16'h4001;
    wr_en = 1; wr_idx = 4'd0; wr_data = 16'h7777;
    inc_en = 1; inc_idx = 4'd0;
    tick();
    chk("R9", pc_out, 16'h4000);

    // R5: constant register ignores writes
    wr(4'd3, 16'h5A5A, 1'b0);
    inc_en = 1; inc_idx = 4'd3;
    tick();
    for (int k = 0; k < 4; k++) begin
      rd_a_idx = 4'd3; rd_a_mode = 2'(k);
      #1;
      chk("R5", rd_a_data, (k == 3) ? 16'hFFFF : 16'(k));
    end
    peek("R5", 4'd3, 16'h0000);

    // R6: status register constants
    wr(4'd2, 16'h0A50, 1'b0);
    for (int k = 0; k < 4; k++) begin
      rd_a_idx = 4'd2; rd_a_mode = 2'(k);
      #1;
      chk("R6", rd_a_data, (k == 2) ? 16'h0004 : (k == 3) ? 16'h0008 : 16'h0A50);
    end

    // R7: step sizes and wrap
    wr(4'd6, 16'h0010, 1'b0);
    inc_en = 1; inc_idx = 4'd6; inc_byte = 1; tick();
    peek("R7", 4'd6, 16'h0011);
    inc_en = 1; inc_idx = 4'd6; tick();
    peek("R7", 4'd6, 16'h0013);
    inc_en = 1; inc_idx = 4'd1; inc_byte = 1; tick();
    chk("R7", sp_out, 16'h1236);
    inc_en = 1; inc_idx = 4'd0; inc_byte = 1; tick();
    chk("R7", pc_out, 16'h4002);
    wr(4'd7, 16'hFFFF, 1'b0);
    inc_en = 1; inc_idx = 4'd7; inc_byte = 1; tick();
    peek("R7", 4'd7, 16'h0000);

    // R8: write beats step on the same entry
    wr_en = 1; wr_idx = 4'd8; wr_data = 16'h1357;
    inc_en = 1; inc_idx = 4'd8;
    tick();
    peek("R8", 4'd8, 16'h1357);

    // R10: flags beat a same-cycle write; flag-only update keeps the rest
    flg_en = 1; flg_val = 4'h0;
    wr_en = 1; wr_idx = 4'd2; wr_data = 16'hFFFF;
    tick();
    chk("R10", sr_out, 16'hFEF8);
    flg_en = 1; flg_val = 4'b1010;
    tick();
    chk("R10", sr_out, 16'hFFFA);

    // Random traffic against the model
    for (int it = 0; it < 1500; it++) begin
      wr_en     = ($urandom % 3) != 0;
      wr_idx    = 4'($urandom);
      wr_byte   = ($urandom % 4) == 0;
      wr_data   = 16'($urandom);
      inc_en    = ($urandom % 3) == 0;
      inc_idx   = 4'($urandom);
      inc_byte  = 1'($urandom);
      pc_en     = ($urandom % 8) == 0;
      pc_data   = 16'($urandom);
      flg_en    = ($urandom % 4) == 0;
      flg_val   = 4'($urandom);
      rd_a_idx  = 4'($urandom);
      rd_a_mode = 2'($urandom);
      rd_b_idx  = 4'($urandom);
      tick();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule